// File: doc/BRIEF.md
# Transmit Dominant-Time Guard

This block sits between the host's transmit line and the enable of a single-wire bus driver. A low level on the transmit line asks for the dominant bus level. A high level asks for recessive. The block measures each low period on the transmit line in clock cycles. If a low period lasts too long, it releases the driver to recessive, so that a transmitter stuck low by a hardware or software fault cannot hold the bus for ever. The driver stays released until the transmit line goes high again.

The limit is set by the parameter `TIMEOUT_CYC`, counted in clock cycles. It should be several milliseconds of clock time, which puts a floor of a few kbit/s on the usable bit rate. The guard also forces the driver off in two other cases: while a thermal-shutdown flag is raised, and while the mode controller does not report normal operation. A level status output shows that a timeout is in force. A one-cycle event output marks the moment the timeout starts.

Top module: `txd_dom_guard`

## Requirements
- R1: While in normal mode, with no thermal shutdown and no timeout in force, `drv_dominant_o` follows the inverse of `txd_i` without delay. Here 1 means drive dominant and 0 means recessive. A high `txd_i` always gives 0.
- R2: While `mode_normal_i` is 0, `drv_dominant_o` is 0 and `timeout_active_o` is 0 from the next clock edge on.
- R3: While `thermal_off_i` is 1, `drv_dominant_o` is 0 whatever `txd_i` is.
- R4: A low period on `txd_i` starts at a falling edge. When it has been sampled low on `TIMEOUT_CYC` consecutive rising clock edges in normal mode, `timeout_active_o` rises and `drv_dominant_o` goes to 0 after that edge. After `TIMEOUT_CYC`-1 such edges, the driver is still dominant.
- R5: After a timeout, the driver stays recessive and `timeout_active_o` stays 1 for as long as `txd_i` stays low. The cycle counter saturates and does not wrap.
- R6: A rising edge on `txd_i` clears `timeout_active_o` at the next clock edge. The next falling edge drives dominant again and restarts a full `TIMEOUT_CYC` window.
- R7: `timeout_pulse_o` is 1 for exactly one cycle, which is the first cycle in which `timeout_active_o` is 1.
- R8: Low periods shorter than `TIMEOUT_CYC` samples never cause a timeout, even when they follow one another closely. Each one starts its count from zero.
- R9: If `txd_i` is already low when reset is released or when normal mode is entered, this counts as a falling edge, and the guard times out after `TIMEOUT_CYC` samples.
- R10: In reset (`rst` is 1, active high, synchronous), `drv_dominant_o`, `timeout_active_o` and `timeout_pulse_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txd_i | input | 1 | Host transmit line, 0 asks for dominant |
| mode_normal_i | input | 1 | Mode controller reports normal operation |
| thermal_off_i | input | 1 | Thermal shutdown in force |
| drv_dominant_o | output | 1 | Driver command, 1 = dominant |
| timeout_active_o | output | 1 | Dominant-time timeout in force |
| timeout_pulse_o | output | 1 | One-cycle event when a timeout starts |

## Verification
The assertions assume that `txd_i`, `mode_normal_i` and `thermal_off_i` are synchronous to `clk`. They also assume that these inputs change only between clock edges, because the driver command is a combinational function of them. The bench always changes its inputs on the falling clock edge and samples outputs there too, away from the sampling edge. The bench keeps `txd_i` high for at least one edge before each deliberate falling edge, so that every window starts from a known edge.

// File: rtl/txd_guard_pkg.sv
package txd_guard_pkg;

    typedef enum logic [1:0] {
        GS_IDLE    = 2'd0,
        GS_TIMING  = 2'd1,
        GS_EXPIRED = 2'd2
    } guard_state_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } txd_edges_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/txd_edge_det.sv
module txd_edge_det
    import txd_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_normal,
    input  logic       txd,
    output txd_edges_t edges
);
    // Outside normal mode or in reset, the line counts as high,
    // so a line that is already low gives a falling edge.
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst || !mode_normal) prev_q <= 1'b1;
        else                     prev_q <= txd;
    end

    always_comb begin
        edges.fall = mode_normal &  prev_q & ~txd;
        edges.rise = mode_normal & ~prev_q &  txd;
    end
endmodule

// File: rtl/dst_timer.sv
module dst_timer
    import txd_guard_pkg::*;
#(
    parameter int unsigned LIMIT = 20000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_normal,
    input  logic         txd,
    input  txd_edges_t   edges,
    output guard_state_e state_o,
    output logic         pulse_o
);
    localparam int unsigned CW = cnt_width(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] SAT  = CW'(LIMIT);

    guard_state_e  state_q;
    logic [CW-1:0] cnt_q;
    logic          pulse_q;

    always_ff @(posedge clk) begin
        if (rst || !mode_normal) begin
            state_q <= GS_IDLE;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (edges.rise) begin
                state_q <= GS_IDLE;
                cnt_q   <= '0;
            end else if (edges.fall) begin
                state_q <= GS_TIMING;
                cnt_q   <= CW'(1);
            end else if (state_q == GS_TIMING && !txd) begin
                if (cnt_q >= LAST) begin
                    state_q <= GS_EXPIRED;
                    cnt_q   <= SAT;
                    pulse_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

    assign state_o = state_q;
    assign pulse_o = pulse_q;
endmodule

// File: rtl/drv_gate.sv
module drv_gate
    import txd_guard_pkg::*;
(
    input  logic         rst,
    input  logic         mode_normal,
    input  logic         thermal_off,
    input  logic         txd,
    input  guard_state_e state,
    output logic         dominant
);
    always_comb begin
        dominant = !rst && mode_normal && !thermal_off && !txd
                   && (state != GS_EXPIRED);
    end
endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard
    import txd_guard_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic txd_i,
    input  logic mode_normal_i,
    input  logic thermal_off_i,
    output logic drv_dominant_o,
    output logic timeout_active_o,
    output logic timeout_pulse_o
);
    txd_edges_t   edges;
    guard_state_e state;

    txd_edge_det edge_i (
        .clk         (clk),
        .rst         (rst),
        .mode_normal (mode_normal_i),
        .txd         (txd_i),
        .edges       (edges)
    );

    dst_timer #(.LIMIT(TIMEOUT_CYC)) timer_i (
        .clk         (clk),
        .rst         (rst),
        .mode_normal (mode_normal_i),
        .txd         (txd_i),
        .edges       (edges),
        .state_o     (state),
        .pulse_o     (timeout_pulse_o)
    );

    drv_gate gate_i (
        .rst         (rst),
        .mode_normal (mode_normal_i),
        .thermal_off (thermal_off_i),
        .txd         (txd_i),
        .state       (state),
        .dominant    (drv_dominant_o)
    );

    assign timeout_active_o = (state == GS_EXPIRED);
endmodule

// File: rtl/txd_dom_guard_chk.sv
module txd_dom_guard_chk (
    input logic clk,
    input logic rst,
    input logic txd_i,
    input logic mode_normal_i,
    input logic thermal_off_i,
    input logic drv_dominant_o,
    input logic timeout_active_o,
    input logic timeout_pulse_o
);
    assert_txd_high_recessive_R1: assert property (@(posedge clk) disable iff (rst)
        txd_i |-> !drv_dominant_o);

    assert_not_normal_off_R2: assert property (@(posedge clk) disable iff (rst)
        !mode_normal_i |-> !drv_dominant_o);

    assert_not_normal_clears_R2: assert property (@(posedge clk) disable iff (rst)
        !mode_normal_i |=> !timeout_active_o);

    assert_thermal_off_R3: assert property (@(posedge clk) disable iff (rst)
        thermal_off_i |-> !drv_dominant_o);

    assert_timeout_releases_R4: assert property (@(posedge clk) disable iff (rst)
        timeout_active_o |-> !drv_dominant_o);

    assert_hold_while_low_R5: assert property (@(posedge clk) disable iff (rst)
        (timeout_active_o && !txd_i && mode_normal_i) |=> timeout_active_o);

    assert_rise_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (timeout_active_o && txd_i && mode_normal_i) |=> !timeout_active_o);

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse_o |=> !timeout_pulse_o);

    assert_pulse_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_active_o) |-> timeout_pulse_o);

    assert_pulse_with_active_R7: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse_o |-> timeout_active_o);

    always @(posedge clk) begin
        if (rst) begin
            assert_reset_quiet_R10: assert (!drv_dominant_o);
        end
    end
endmodule

bind txd_dom_guard txd_dom_guard_chk chk_i (
    .clk              (clk),
    .rst              (rst),
    .txd_i            (txd_i),
    .mode_normal_i    (mode_normal_i),
    .thermal_off_i    (thermal_off_i),
    .drv_dominant_o   (drv_dominant_o),
    .timeout_active_o (timeout_active_o),
    .timeout_pulse_o  (timeout_pulse_o)
);

// File: tb/txd_dom_guard_tb.sv
module txd_dom_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LIM        = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txd = 1'b1;
    logic normal = 1'b0;
    logic thermal = 1'b0;
    logic drv, active, pulse;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txd_dom_guard #(.TIMEOUT_CYC(LIM)) dut_i (
        .clk              (clk),
        .rst              (rst),
        .txd_i            (txd),
        .mode_normal_i    (normal),
        .thermal_off_i    (thermal),
        .drv_dominant_o   (drv),
        .timeout_active_o (active),
        .timeout_pulse_o  (pulse)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic go_idle_high();
        txd = 1'b1; normal = 1'b1; thermal = 1'b0;
        cyc(2);
    endtask

    task automatic t_reset();
        cyc(2);
        chk("R10", "drv in reset", drv, 1'b0);
        chk("R10", "active in reset", active, 1'b0);
        chk("R10", "pulse in reset", pulse, 1'b0);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic t_follow();
        go_idle_high();
        chk("R1", "high gives recessive", drv, 1'b0);
        txd = 1'b0; #1;
        chk("R1", "low gives dominant", drv, 1'b1);
        cyc(3);
        chk("R1", "still dominant", drv, 1'b1);
        txd = 1'b1; #1;
        chk("R1", "back to recessive", drv, 1'b0);
        cyc(1);
    endtask

    task automatic t_timeout();
        go_idle_high();
        txd = 1'b0;
        cyc(LIM - 1);
        chk("R4", "dominant before limit", drv, 1'b1);
        chk("R4", "not active before limit", active, 1'b0);
        cyc(1);
        chk("R4", "released at limit", drv, 1'b0);
        chk("R4", "active at limit", active, 1'b1);
        chk("R7", "pulse first cycle", pulse, 1'b1);
        cyc(1);
        chk("R7", "pulse gone", pulse, 1'b0);
        cyc(3 * LIM);
        chk("R5", "still released", drv, 1'b0);
        chk("R5", "still active", active, 1'b1);
        chk("R5", "no second pulse", pulse, 1'b0);
        txd = 1'b1;
        cyc(1);
        chk("R6", "rise clears", active, 1'b0);
        txd = 1'b0; #1;
        chk("R6", "dominant again", drv, 1'b1);
        cyc(LIM - 1);
        chk("R6", "full window restarted", drv, 1'b1);
        cyc(1);
        chk("R6", "second timeout", active, 1'b1);
        txd = 1'b1;
        cyc(1);
    endtask

    task automatic t_short();
        go_idle_high();
        for (int k = 0; k < 3; k++) begin
            txd = 1'b0;
            cyc(LIM - 1);
            txd = 1'b1;
            cyc(1);
        end
        txd = 1'b0;
        cyc(LIM - 1);
        chk("R8", "short lows no timeout", active, 1'b0);
        chk("R8", "short lows dominant", drv, 1'b1);
        txd = 1'b1;
        cyc(1);
    endtask

    task automatic t_thermal_mode();
        go_idle_high();
        txd = 1'b0; thermal = 1'b1; #1;
        chk("R3", "thermal forces recessive", drv, 1'b0);
        thermal = 1'b0; #1;
        chk("R3", "thermal cleared dominant", drv, 1'b1);
        normal = 1'b0; #1;
        chk("R2", "not normal recessive", drv, 1'b0);
        cyc(2 * LIM);
        chk("R2", "no timeout outside normal", active, 1'b0);
        normal = 1'b1;
        cyc(LIM - 1);
        chk("R9", "enter normal low dominant", drv, 1'b1);
        cyc(1);
        chk("R9", "enter normal low times out", active, 1'b1);
        normal = 1'b0;
        cyc(1);
        chk("R2", "leaving normal clears", active, 1'b0);
        txd = 1'b1;
        cyc(1);
    endtask

    task automatic t_reset_low();
        txd = 1'b0; normal = 1'b1; rst = 1'b1;
        cyc(2);
        chk("R10", "drv held off in reset", drv, 1'b0);
        rst = 1'b0;
        cyc(LIM - 1);
        chk("R9", "after reset still dominant", drv, 1'b1);
        cyc(1);
        chk("R9", "after reset times out", active, 1'b1);
        txd = 1'b1;
        cyc(1);
    endtask

    initial begin
        t_reset();
        t_follow();
        t_timeout();
        t_short();
        t_thermal_mode();
        t_reset_low();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule